// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the software-visible control state of a group of descriptor-driven DMA channels. Each channel owns a 16-bit status word, a 32-bit command pointer and three condition-select words, all reached through a single word-wide write/read port. Software never writes the status word's run state directly. It writes a control word whose upper half is a per-bit enable for the lower half. The block merges that into the status word and then applies the run, pause and wake rules that decide whether the channel is active.

Three single-cycle strobes per channel connect the bank to the executor. A start strobe fires when a control write moves the channel from idle to active. A fetch strobe fires when a new command pointer has been accepted. A flush strobe fires when software stops a running channel with the flush bit set. The command pointer is locked while the channel is active, and every accepted value is forced to a 16-byte boundary.

Word address layout: `{channel, offset[2:0]}`. The offsets are 0 control, 1 status, 2 command pointer, 3 interrupt select, 4 branch select, 5 wait select, and 6 and 7 reserved.

Top module: `dmareg_bank`

## Requirements
- R1: After reset every register of every channel reads as zero, and no strobe is asserted.
- R2: A control write (offset 0) takes mask = wdata[31:16] and value = wdata[15:0]. Only value bits 15 (RUN), 14 (PAUSE), 13 (FLUSH), 12 (WAKE) and 3:0 (device status) can be written. The pre-rule status becomes (value & writable & mask) | (old & ~mask), so a masked non-writable bit is cleared. Reading offset 0 returns zero.
- R3: After the merge, WAKE set forces ACTIVE (bit 10). RUN set forces ACTIVE and clears DEAD (bit 11). PAUSE set clears ACTIVE, and this rule takes precedence over the other two.
- R4: When a control write takes RUN from 1 to 0, ACTIVE and DEAD are cleared. If FLUSH is then set, FLUSH is cleared and a one-cycle flush strobe is asserted in the cycle after the write.
- R5: A one-cycle start strobe is asserted in the cycle after a control write only if ACTIVE was 0 before that write and is 1 after it.
- R6: A command-pointer write (offset 2) is dropped while ACTIVE is set. An accepted write stores the value with bits 3:0 cleared and asserts a one-cycle fetch strobe in the next cycle.
- R7: A direct status write (offset 1) stores wdata[15:0] with no side effects and no strobe. Bits 31:16 of the status word read as zero.
- R8: The three select registers (offsets 3, 4, 5) keep only bits 19:16 and 3:0, and every other bit reads as zero.
- R9: Reserved offsets 6 and 7 read as zero. The channel field of the address selects the channel, and a write to one channel leaves every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_addr | input | CH_W+3 | Word address {channel, offset} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ch_status | output | NCH*16 | Status word of each channel |
| ch_cmdptr | output | NCH*32 | Command pointer of each channel |
| ch_start | output | NCH | Start strobe per channel |
| ch_fetch | output | NCH | Descriptor fetch strobe per channel |
| ch_flush | output | NCH | Flush strobe per channel |

## Verification
The bench sweeps every combination of the six run-related status bits against every mask/value pattern of the four writable control bits. This covers the idle-to-active edge and the masked clearing of a non-writable bit such as ACTIVE. A design that let WAKE or RUN override PAUSE would report ACTIVE while paused. A design that tested the post-write RUN instead of the RUN transition would miss flushes or raise spurious ones, and a design that strobed start on every active write would repeat starts. The bench also writes the pointer while the channel is active, where a design that forgot the lock would let software move a running pointer. It further checks that strobes stay silent on a direct status write, which shows that side effects are confined to the control register.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;
  localparam int B_BT     = 8;

  localparam int STAT_W = 16;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 3;
  localparam int NSEL   = 3;

  localparam logic [STAT_W-1:0] WRITABLE = 16'hF00F;
  localparam logic [WORD_W-1:0] SEL_KEEP = 32'h000F_000F;

  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_PTR  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_SEL0 = 3'd3;
endpackage

// File: rtl/dmareg_merge.sv
module dmareg_merge
  import dmareg_pkg::*;
(
  input  logic [STAT_W-1:0] old_stat,
  input  logic [WORD_W-1:0] wdata,
  output logic [STAT_W-1:0] new_stat,
  output logic              flush_hit
);
  logic [STAT_W-1:0] val;
  logic [STAT_W-1:0] msk;
  logic [STAT_W-1:0] s;

  always_comb begin
    val = wdata[STAT_W-1:0] & WRITABLE;
    msk = wdata[WORD_W-1:STAT_W];
    s   = (val & msk) | (old_stat & ~msk);
    if (s[B_WAKE]) s[B_ACTIVE] = 1'b1;
    if (s[B_RUN]) begin
      s[B_ACTIVE] = 1'b1;
      s[B_DEAD]   = 1'b0;
    end
    if (s[B_PAUSE]) s[B_ACTIVE] = 1'b0;
    flush_hit = 1'b0;
    if (old_stat[B_RUN] && !s[B_RUN]) begin
      s[B_ACTIVE] = 1'b0;
      s[B_DEAD]   = 1'b0;
      if (s[B_FLUSH]) begin
        flush_hit  = 1'b1;
        s[B_FLUSH] = 1'b0;
      end
    end
    new_stat = s;
  end
endmodule

// File: rtl/dmareg_channel.sv
module dmareg_channel
  import dmareg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [OFF_W-1:0]       wr_off,
  input  logic [WORD_W-1:0]      wdata,
  output logic [STAT_W-1:0]      status_o,
  output logic [WORD_W-1:0]      cmdptr_o,
  output logic [NSEL*WORD_W-1:0] sel_o,
  output logic                   start_o,
  output logic                   fetch_o,
  output logic                   flush_o
);
  logic [STAT_W-1:0] stat_q, stat_d, merged;
  logic [WORD_W-1:0] ptr_q, ptr_d;
  logic              flush_hit;
  logic              wr_ctrl, wr_stat, wr_ptr, stat_en, ptr_en;
  logic              start_q, start_d, fetch_q, fetch_d, flush_q, flush_d;

  dmareg_merge u_merge (
    .old_stat (stat_q),
    .wdata    (wdata),
    .new_stat (merged),
    .flush_hit(flush_hit)
  );

  always_comb begin
    wr_ctrl = wr_en && (wr_off == OFF_CTRL);
    wr_stat = wr_en && (wr_off == OFF_STAT);
    wr_ptr  = wr_en && (wr_off == OFF_PTR);
    stat_en = wr_ctrl || wr_stat;
    stat_d  = wr_ctrl ? merged : wdata[STAT_W-1:0];
    ptr_en  = wr_ptr && !stat_q[B_ACTIVE];
    ptr_d   = {wdata[WORD_W-1:4], 4'b0000};
    start_d = wr_ctrl && merged[B_ACTIVE] && !stat_q[B_ACTIVE];
    flush_d = wr_ctrl && flush_hit;
    fetch_d = ptr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      ptr_q   <= '0;
      start_q <= 1'b0;
      fetch_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      start_q <= start_d;
      fetch_q <= fetch_d;
      flush_q <= flush_d;
    end
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    logic [WORD_W-1:0] sel_q, sel_d;
    logic              sel_en;
    always_comb begin
      sel_en = wr_en && (wr_off == OFF_SEL0 + OFF_W'(k));
      sel_d  = wdata & SEL_KEEP;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_en) sel_q <= sel_d;
    end
    assign sel_o[k*WORD_W +: WORD_W] = sel_q;
  end

  assign status_o = stat_q;
  assign cmdptr_o = ptr_q;
  assign start_o  = start_q;
  assign fetch_o  = fetch_q;
  assign flush_o  = flush_q;

  AST_PAUSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !(stat_q[B_PAUSE] && stat_q[B_ACTIVE])); // R3
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (!stat_q[B_FLUSH] && !stat_q[B_RUN] && !stat_q[B_ACTIVE])); // R4
  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (stat_q[B_ACTIVE] && !$past(stat_q[B_ACTIVE]))); // R5
  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr && stat_q[B_ACTIVE]) |=> ($stable(ptr_q) && !fetch_o)); // R6
  AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> (ptr_q[3:0] == 4'd0)); // R6
  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, fetch_o})); // R5
endmodule

// File: rtl/dmareg_rdmux.sv
module dmareg_rdmux
  import dmareg_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic [CH_W+OFF_W-1:0]       addr,
  input  logic [NCH*STAT_W-1:0]       stat_all,
  input  logic [NCH*WORD_W-1:0]       ptr_all,
  input  logic [NCH*NSEL*WORD_W-1:0]  sel_all,
  output logic [WORD_W-1:0]           rdata
);
  logic [CH_W-1:0]  ch;
  logic [OFF_W-1:0] off;

  always_comb begin
    ch    = addr[CH_W+OFF_W-1:OFF_W];
    off   = addr[OFF_W-1:0];
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch == CH_W'(i)) begin
        case (off)
          OFF_STAT: rdata = {{(WORD_W-STAT_W){1'b0}}, stat_all[i*STAT_W +: STAT_W]};
          OFF_PTR:  rdata = ptr_all[i*WORD_W +: WORD_W];
          3'd3:     rdata = sel_all[(i*NSEL+0)*WORD_W +: WORD_W];
          3'd4:     rdata = sel_all[(i*NSEL+1)*WORD_W +: WORD_W];
          3'd5:     rdata = sel_all[(i*NSEL+2)*WORD_W +: WORD_W];
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [CH_W+OFF_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic [NCH*STAT_W-1:0]   ch_status,
  output logic [NCH*WORD_W-1:0]   ch_cmdptr,
  output logic [NCH-1:0]          ch_start,
  output logic [NCH-1:0]          ch_fetch,
  output logic [NCH-1:0]          ch_flush
);
  localparam int ADDR_W = CH_W + OFF_W;

  logic [NCH*NSEL*WORD_W-1:0] sel_all;
  logic [CH_W-1:0]            wr_ch;
  logic [OFF_W-1:0]           wr_off;

  assign wr_ch  = bus_addr[ADDR_W-1:OFF_W];
  assign wr_off = bus_addr[OFF_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = bus_wr && (wr_ch == CH_W'(c));
    dmareg_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ch_wr),
      .wr_off  (wr_off),
      .wdata   (bus_wdata),
      .status_o(ch_status[c*STAT_W +: STAT_W]),
      .cmdptr_o(ch_cmdptr[c*WORD_W +: WORD_W]),
      .sel_o   (sel_all[c*NSEL*WORD_W +: NSEL*WORD_W]),
      .start_o (ch_start[c]),
      .fetch_o (ch_fetch[c]),
      .flush_o (ch_flush[c])
    );
  end

  dmareg_rdmux #(.NCH(NCH), .CH_W(CH_W)) u_rd (
    .addr    (bus_addr),
    .stat_all(ch_status),
    .ptr_all (ch_cmdptr),
    .sel_all (sel_all),
    .rdata   (bus_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ch_start == '0 && ch_fetch == '0 && ch_flush == '0)); // R1
  AST_ONE_CH_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_start | ch_fetch | ch_flush) <= 1); // R9
endmodule

// File: tb/tb_dmareg_bank.sv
module tb_dmareg_bank;
  localparam int CLK_P = 10;
  localparam int NCH   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ch_status;
  logic [63:0] ch_cmdptr;
  logic [1:0]  ch_start, ch_fetch, ch_flush;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dmareg_bank #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_status(ch_status),
    .ch_cmdptr(ch_cmdptr), .ch_start(ch_start), .ch_fetch(ch_fetch),
    .ch_flush(ch_flush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {ch[0], off[2:0]}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    bus_addr = {ch[0], off[2:0]};
    #1;
    d = bus_rdata;
  endtask

  // expected result of a control word applied to an old status: {flush, status}
  function automatic logic [16:0] model(input logic [15:0] old, input logic [31:0] wd);
    logic [15:0] s, m;
    logic f;
    m = wd[31:16];
    s = (wd[15:0] & 16'hF00F & m) | (old & ~m);
    if (s[12]) s[10] = 1'b1;
    if (s[15]) begin s[10] = 1'b1; s[11] = 1'b0; end
    if (s[14]) s[10] = 1'b0;
    f = 1'b0;
    if (old[15] && !s[15]) begin
      s[10] = 1'b0; s[11] = 1'b0;
      if (s[13]) begin f = 1'b1; s[13] = 1'b0; end
    end
    return {f, s};
  endfunction

  initial begin
    logic [31:0] r;
    logic [15:0] old;
    logic [31:0] cw;
    logic [16:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 8; o++) begin
        rd(c, o, r);
        chk("R1", r, 32'h0);
      end
    chk("R1 strobes", {26'h0, ch_start, ch_fetch, ch_flush}, 32'h0);

    // R8 select registers
    wr(0, 3, 32'hFFFF_FFFF); rd(0, 3, r); chk("R8", r, 32'h000F_000F);
    wr(0, 4, 32'h1234_5678); rd(0, 4, r); chk("R8", r, 32'h0004_0008);
    wr(0, 5, 32'hABCD_EF91); rd(0, 5, r); chk("R8", r, 32'h000D_0001);
    // R9 reserved offsets
    wr(0, 6, 32'hFFFF_FFFF); rd(0, 6, r); chk("R9", r, 32'h0);
    wr(0, 7, 32'hFFFF_FFFF); rd(0, 7, r); chk("R9", r, 32'h0);

    // R6 pointer accepted while idle
    wr(0, 2, 32'h1234_567F);
    chk("R6 fetch", {31'h0, ch_fetch[0]}, 32'h1);
    rd(0, 2, r); chk("R6 align", r, 32'h1234_5670);
    @(negedge clk);
    chk("R6 one-cycle", {31'h0, ch_fetch[0]}, 32'h0);

    // R2 control reads zero
    wr(0, 0, 32'h8000_8000);
    chk("R5 start", {31'h0, ch_start[0]}, 32'h1);
    rd(0, 0, r); chk("R2 ctrl read", r, 32'h0);
    rd(0, 1, r); chk("R3 run", r, 32'h0000_8400);
    // R6 pointer locked while active
    wr(0, 2, 32'hAAAA_AAA0);
    chk("R6 no fetch", {31'h0, ch_fetch[0]}, 32'h0);
    rd(0, 2, r); chk("R6 locked", r, 32'h1234_5670);
    chk("R6 port", ch_cmdptr[31:0], 32'h1234_5670);

    // R9 channel independence
    wr(1, 0, 32'h9000_9000);
    chk("R9 ch1 start", {30'h0, ch_start}, 32'h2);
    rd(1, 1, r); chk("R9 ch1 stat", r, 32'h0000_9400);
    rd(0, 1, r); chk("R9 ch0 kept", r, 32'h0000_8400);
    rd(1, 2, r); chk("R9 ch1 ptr", r, 32'h0);
    rd(1, 3, r); chk("R9 ch1 sel", r, 32'h0);

    // R7 direct status write: no strobes, upper half zero
    wr(1, 1, 32'hFFFF_0000);
    wr(1, 1, 32'hFFFF_A40C);
    chk("R7 no strobe", {26'h0, ch_start, ch_fetch, ch_flush}, 32'h0);
    rd(1, 1, r); chk("R7", r, 32'h0000_A40C);
    chk("R7 port", {16'h0, ch_status[31:16]}, 32'h0000_A40C);
    // R4 stop with flush pending
    wr(1, 0, 32'h8000_0000);
    chk("R4 flush strobe", {30'h0, ch_flush}, 32'h2);
    rd(1, 1, r); chk("R4 cleared", r, 32'h0000_000C);
    @(negedge clk);
    chk("R4 one-cycle", {30'h0, ch_flush}, 32'h0);

    // sweep: old RUN,PAUSE,FLUSH,WAKE,DEAD,ACTIVE x control patterns (R2..R5)
    for (int o = 0; o < 64; o++) begin
      for (int c = 0; c < 256; c++) begin
        old = {o[5], o[4], o[3], o[2], o[1], o[0], 6'b0, o[3:0] ^ 4'h3};
        cw  = {c[3:0], 1'b0, c[1] & c[6], 6'b0, c[3:0],
               c[7:4], 1'b0, c[2], 6'b0, c[7:4]};
        wr(0, 1, {16'h0, old});
        wr(0, 0, cw);
        e = model(old, cw);
        chk("R5 start", {31'h0, ch_start[0]}, {31'h0, e[10] & ~old[10]});
        chk("R4 flush", {31'h0, ch_flush[0]}, {31'h0, e[16]});
        rd(0, 1, r);
        chk("R2 R3 status", r, {16'h0, e[15:0]});
      end
    end
    rd(0, 2, r); chk("R6 kept through sweep", r, 32'h1234_5670);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule